// File: doc/BRIEF.md
# Pipeline Bypass and Interlock Controller

This block steers the operand bypass paths and raises the single stall line of a five-stage in-order 32-bit pipeline: fetch, decode with register read, execute, memory, writeback. Both memories are fully synchronous, so the data memory returns load data during the memory stage. Branch compares and branch targets are resolved in decode. Every control transfer has one delay slot, so the block never flushes anything.

Each cycle the block takes three groups of inputs. From decode it takes the two source specifiers, their use flags and a branch flag. From execute and memory it takes the destination specifier, write enable and load flag. From writeback it takes the destination specifier and write enable. It returns two kinds of select. The decode-side selects are combinational and feed the branch comparator and the operand latch into execute. The execute-side selects are computed while the instruction is still in decode and are registered, so they are ready at the start of the execute cycle. A stall holds PC and decode, and it turns the execute-side selects into a bubble.

Top module: `hazard_ctrl`

## Requirements
- R1: Select encoding is 2'b00 register file or latched operand, 2'b01 memory-stage result and 2'b10 writeback result. One cycle after an instruction leaves decode without a stall, its execute select for an operand is 2'b01 if, while it was in decode, the execute-stage instruction had write enable set and a matching nonzero destination. Otherwise it is 2'b10 if the memory-stage instruction had write enable set and a matching nonzero destination. Otherwise it is 2'b00.
- R2: When more than one later stage writes the same register, the youngest producer wins: execute before memory for the execute selects, and memory before writeback for the decode selects.
- R3: Register 0 is never forwarded and never causes a stall.
- R4: A source in use that matches the nonzero destination of a load in execute raises the stall in that same cycle.
- R5: One cycle after a stall, both execute selects are 2'b00, which marks the bubble. When the load has moved to the memory stage and the consumer then leaves decode, the consumer's execute select is 2'b10.
- R6: A non-branch instruction never stalls on an ALU result, and it never stalls on a load two or three instructions ahead.
- R7: A decode select is 2'b01 when the memory-stage instruction writes the matching nonzero register and is not a load. It is 2'b10 when only the writeback stage matches. It is 2'b00 when the memory-stage match is a load.
- R8: A branch in decode stalls when one of its used sources matches an execute-stage producer of any kind, or a load in the memory stage.
- R9: A source whose use flag is low never gets a bypass select and never causes a stall.
- R10: While reset is held, both execute selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_rs_i | input | 5 | Decode first source specifier |
| id_rt_i | input | 5 | Decode second source specifier |
| id_use_rs_i | input | 1 | First source is read |
| id_use_rt_i | input | 1 | Second source is read |
| id_branch_i | input | 1 | Decode holds a compare branch |
| ex_rd_i | input | 5 | Execute destination |
| ex_wr_i | input | 1 | Execute writes a register |
| ex_load_i | input | 1 | Execute holds a load |
| mem_rd_i | input | 5 | Memory-stage destination |
| mem_wr_i | input | 1 | Memory stage writes a register |
| mem_load_i | input | 1 | Memory stage holds a load |
| wb_rd_i | input | 5 | Writeback destination |
| wb_wr_i | input | 1 | Writeback writes a register |
| stall_o | output | 1 | Hold PC and decode, bubble into execute |
| id_sel_a_o | output | 2 | Decode bypass select, first source |
| id_sel_b_o | output | 2 | Decode bypass select, second source |
| ex_sel_a_o | output | 2 | Execute bypass select, first operand |
| ex_sel_b_o | output | 2 | Execute bypass select, second operand |

## Verification
The assertions take for granted that the stage inputs describe a consistent pipeline. The execute and memory fields have to be the instructions that were in decode and in execute one cycle earlier, and a bubble has to carry write enable low. Most stimulus vectors stand alone, because the registered selects depend only on the inputs at the preceding edge. The stall and drain sequence is driven by hand so that it moves the load forward as a real pipeline would. The delay checks on the registered selects then compare against inputs that were actually present in decode.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MEM = 2'b01,
    SRC_WB  = 2'b10
  } src_e;

  localparam int unsigned N_OPS = 2;
endpackage

// File: rtl/hz_hit.sv
module hz_hit #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic          use_i,
  input  logic [AW-1:0] dst_i,
  input  logic          wr_i,
  output logic          hit_o
);
  assign hit_o = use_i && wr_i && (dst_i != '0) && (dst_i == src_i);
endmodule

// File: rtl/hz_pick.sv
module hz_pick
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic          use_i,
  input  logic [AW-1:0] near_dst_i,
  input  logic          near_wr_i,
  input  logic          near_ok_i,
  input  logic [AW-1:0] far_dst_i,
  input  logic          far_wr_i,
  output src_e          sel_o
);
  logic near_hit, far_hit;

  hz_hit #(.AW(AW)) u_near (
    .src_i(src_i), .use_i(use_i), .dst_i(near_dst_i), .wr_i(near_wr_i), .hit_o(near_hit)
  );
  hz_hit #(.AW(AW)) u_far (
    .src_i(src_i), .use_i(use_i), .dst_i(far_dst_i), .wr_i(far_wr_i), .hit_o(far_hit)
  );

  // a near match that cannot be bypassed masks older producers
  always_comb begin
    if (near_hit)     sel_o = near_ok_i ? SRC_MEM : SRC_RF;
    else if (far_hit) sel_o = SRC_WB;
    else              sel_o = SRC_RF;
  end
endmodule

// File: rtl/hz_stall.sv
module hz_stall
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_OPS-1:0][AW-1:0]   src_i,
  input  logic [N_OPS-1:0]           use_i,
  input  logic                       branch_i,
  input  logic [AW-1:0]              ex_rd_i,
  input  logic                       ex_wr_i,
  input  logic                       ex_load_i,
  input  logic [AW-1:0]              mem_rd_i,
  input  logic                       mem_wr_i,
  input  logic                       mem_load_i,
  output logic                       stall_o
);
  logic [N_OPS-1:0] ex_hit, mem_hit;

  for (genvar g = 0; g < N_OPS; g++) begin : g_hit
    hz_hit #(.AW(AW)) u_ex (
      .src_i(src_i[g]), .use_i(use_i[g]), .dst_i(ex_rd_i), .wr_i(ex_wr_i), .hit_o(ex_hit[g])
    );
    hz_hit #(.AW(AW)) u_mem (
      .src_i(src_i[g]), .use_i(use_i[g]), .dst_i(mem_rd_i), .wr_i(mem_wr_i), .hit_o(mem_hit[g])
    );
  end

  logic load_use, br_wait;
  assign load_use = ex_load_i && (|ex_hit);
  // decode comparator cannot take an execute result or late load data
  assign br_wait  = branch_i && ((|ex_hit) || (mem_load_i && (|mem_hit)));
  assign stall_o  = load_use || br_wait;

  p_stall_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_load_i || branch_i));
  p_no_alu_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!branch_i && !ex_load_i) |-> !stall_o);
  p_zero_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i[0] == '0 && src_i[1] == '0) |-> !stall_o);
endmodule

// File: rtl/hz_ex_sel_reg.sv
module hz_ex_sel_reg
  import hz_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   stall_i,
  input  logic [N_OPS-1:0][1:0]  nxt_i,
  output logic [N_OPS-1:0][1:0]  q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (stall_i) q_o <= '0;
    else              q_o <= nxt_i;
  end

  p_bubble_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> (q_o == '0));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_use_rs_i,
  input  logic          id_use_rt_i,
  input  logic          id_branch_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_wr_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_wr_i,
  input  logic          mem_load_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_wr_i,
  output logic          stall_o,
  output logic [1:0]    id_sel_a_o,
  output logic [1:0]    id_sel_b_o,
  output logic [1:0]    ex_sel_a_o,
  output logic [1:0]    ex_sel_b_o
);
  logic [N_OPS-1:0][AW-1:0] src;
  logic [N_OPS-1:0]         use_v;
  logic [N_OPS-1:0][1:0]    id_sel, ex_nxt, ex_q;

  assign src   = {id_rt_i, id_rs_i};
  assign use_v = {id_use_rt_i, id_use_rs_i};

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    src_e id_e, nxt_e;

    // decode read: memory-stage ALU result, else writeback
    hz_pick #(.AW(AW)) u_id_pick (
      .src_i(src[g]), .use_i(use_v[g]),
      .near_dst_i(mem_rd_i), .near_wr_i(mem_wr_i), .near_ok_i(!mem_load_i),
      .far_dst_i(wb_rd_i), .far_wr_i(wb_wr_i),
      .sel_o(id_e)
    );
    // execute select precomputed one stage early
    hz_pick #(.AW(AW)) u_ex_pick (
      .src_i(src[g]), .use_i(use_v[g]),
      .near_dst_i(ex_rd_i), .near_wr_i(ex_wr_i), .near_ok_i(1'b1),
      .far_dst_i(mem_rd_i), .far_wr_i(mem_wr_i),
      .sel_o(nxt_e)
    );
    assign id_sel[g] = id_e;
    assign ex_nxt[g] = nxt_e;
  end

  hz_stall #(.AW(AW)) u_stall (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .src_i(src), .use_i(use_v), .branch_i(id_branch_i),
    .ex_rd_i(ex_rd_i), .ex_wr_i(ex_wr_i), .ex_load_i(ex_load_i),
    .mem_rd_i(mem_rd_i), .mem_wr_i(mem_wr_i), .mem_load_i(mem_load_i),
    .stall_o(stall_o)
  );

  hz_ex_sel_reg u_ex_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_o), .nxt_i(ex_nxt), .q_o(ex_q)
  );

  assign id_sel_a_o = id_sel[0];
  assign id_sel_b_o = id_sel[1];
  assign ex_sel_a_o = ex_q[0];
  assign ex_sel_b_o = ex_q[1];

  p_id_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs_i == '0) |-> (id_sel_a_o == SRC_RF));
  p_id_mem_alu_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_sel_a_o == SRC_MEM) |-> (mem_wr_i && !mem_load_i));
  p_ex_from_ex_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_sel_a_o == SRC_MEM) |-> $past(ex_wr_i && ex_rd_i != '0 && id_use_rs_i));
  p_br_on_ex_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_branch_i && id_use_rs_i && ex_wr_i && ex_rd_i == id_rs_i && ex_rd_i != '0)
      |-> stall_o);
  p_unused_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_use_rs_i && !id_use_rt_i) |-> (!stall_o && id_sel_a_o == SRC_RF));
endmodule

// File: tb/hazard_ctrl_test.sv
`timescale 1ns/1ps
module hazard_ctrl_test;
  localparam logic [1:0] SR = 2'd0, SM = 2'd1, SW = 2'd2;

  typedef struct packed {
    logic [4:0] rs; logic [4:0] rt; logic ur; logic ut; logic br;
    logic [4:0] exd; logic exw; logic exl;
    logic [4:0] md; logic mw; logic ml;
    logic [4:0] wd; logic ww;
    logic st; logic [1:0] ia; logic [1:0] ib; logic [1:0] ea; logic [1:0] eb;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // rs  rt  ur ut br  exd w l   md  w l   wd  w   st ia ib ea eb req
    '{5'd1, 5'd2, 1,1,0, 5'd5,1,0, 5'd6,1,0, 5'd7,1, 0, SR,SR,SR,SR, 1},  // R1 none
    '{5'd3, 5'd4, 1,1,0, 5'd3,1,0, 5'd4,1,0, 5'd0,0, 0, SR,SM,SM,SW, 1},  // R1
    '{5'd8, 5'd8, 1,1,0, 5'd8,1,0, 5'd8,1,0, 5'd8,1, 0, SM,SM,SM,SM, 2},  // R2
    '{5'd0, 5'd0, 1,1,1, 5'd0,1,1, 5'd0,1,0, 5'd0,1, 0, SR,SR,SR,SR, 3},  // R3
    '{5'd9, 5'd2, 1,1,0, 5'd9,1,1, 5'd0,0,0, 5'd0,0, 1, SR,SR,SR,SR, 4},  // R4
    '{5'd1, 5'd9, 1,1,0, 5'd9,1,1, 5'd0,0,0, 5'd0,0, 1, SR,SR,SR,SR, 4},  // R4
    '{5'd9, 5'd2, 0,1,0, 5'd9,1,1, 5'd0,0,0, 5'd0,0, 0, SR,SR,SR,SR, 9},  // R9
    '{5'd10,5'd1, 1,0,0, 5'd5,1,0, 5'd10,1,1, 5'd0,0, 0, SR,SR,SW,SR, 6}, // R6 dist 2
    '{5'd11,5'd1, 1,0,0, 5'd5,1,0, 5'd6,1,0, 5'd11,1, 0, SW,SR,SR,SR, 6}, // R6 dist 3
    '{5'd12,5'd1, 1,0,0, 5'd12,1,0, 5'd0,0,0, 5'd0,0, 0, SR,SR,SM,SR, 6}, // R6 alu
    '{5'd12,5'd1, 1,0,1, 5'd12,1,0, 5'd0,0,0, 5'd0,0, 1, SR,SR,SR,SR, 8}, // R8
    '{5'd13,5'd14,1,1,1, 5'd0,0,0, 5'd13,1,1, 5'd0,0, 1, SR,SR,SR,SR, 8}, // R8
    '{5'd13,5'd1, 1,0,1, 5'd0,0,0, 5'd13,1,0, 5'd0,0, 0, SM,SR,SW,SR, 7}, // R7
    '{5'd1, 5'd15,1,1,1, 5'd0,0,0, 5'd0,0,0, 5'd15,1, 0, SR,SW,SR,SR, 7}, // R7
    '{5'd3, 5'd1, 1,0,0, 5'd3,0,1, 5'd0,0,0, 5'd0,0, 0, SR,SR,SR,SR, 1},  // R1 no write
    '{5'd1, 5'd6, 1,0,1, 5'd6,1,0, 5'd0,0,0, 5'd0,0, 0, SR,SR,SR,SR, 9}   // R9 bgez rt
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] id_rs, id_rt, ex_rd, mem_rd, wb_rd;
  logic id_use_rs, id_use_rt, id_branch, ex_wr, ex_load, mem_wr, mem_load, wb_wr;
  logic stall;
  logic [1:0] id_sel_a, id_sel_b, ex_sel_a, ex_sel_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hazard_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_use_rs_i(id_use_rs), .id_use_rt_i(id_use_rt),
    .id_branch_i(id_branch),
    .ex_rd_i(ex_rd), .ex_wr_i(ex_wr), .ex_load_i(ex_load),
    .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .mem_load_i(mem_load),
    .wb_rd_i(wb_rd), .wb_wr_i(wb_wr),
    .stall_o(stall), .id_sel_a_o(id_sel_a), .id_sel_b_o(id_sel_b),
    .ex_sel_a_o(ex_sel_a), .ex_sel_b_o(ex_sel_b)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    id_rs = v.rs; id_rt = v.rt; id_use_rs = v.ur; id_use_rt = v.ut; id_branch = v.br;
    ex_rd = v.exd; ex_wr = v.exw; ex_load = v.exl;
    mem_rd = v.md; mem_wr = v.mw; mem_load = v.ml;
    wb_rd = v.wd; wb_wr = v.ww;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    // R10: hazard present while reset is held
    apply('{5'd3, 5'd4, 1,1,0, 5'd3,1,0, 5'd4,1,0, 5'd0,0, 0, SR,SR,SR,SR, 10});
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset ex_sel_a", ex_sel_a, SR);
    chk("R10 reset ex_sel_b", ex_sel_b, SR);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      #1;
      chk($sformatf("R%0d v%0d stall", VEC[i].req, i), stall, VEC[i].st);
      chk($sformatf("R%0d v%0d id_sel_a", VEC[i].req, i), id_sel_a, VEC[i].ia);
      chk($sformatf("R%0d v%0d id_sel_b", VEC[i].req, i), id_sel_b, VEC[i].ib);
      @(posedge clk);
      #1;
      chk($sformatf("R%0d v%0d ex_sel_a", VEC[i].req, i), ex_sel_a, VEC[i].ea);
      chk($sformatf("R%0d v%0d ex_sel_b", VEC[i].req, i), ex_sel_b, VEC[i].eb);
    end

    // R5: load then consumer, stall, then drain into writeback bypass
    @(negedge clk);
    apply('{5'd9, 5'd1, 1,0,0, 5'd9,1,1, 5'd4,1,0, 5'd0,0, 0, SR,SR,SR,SR, 5});
    #1;
    chk("R4 seq stall on load-use", stall, 1);
    @(posedge clk);
    #1;
    chk("R5 bubble ex_sel_a", ex_sel_a, SR);
    @(negedge clk);
    ex_wr = 1'b0; ex_load = 1'b0; ex_rd = 5'd0;
    mem_rd = 5'd9; mem_wr = 1'b1; mem_load = 1'b1;
    wb_rd = 5'd4; wb_wr = 1'b1;
    #1;
    chk("R5 stall released", stall, 0);
    chk("R7 load in mem not bypassed to decode", id_sel_a, SR);
    @(posedge clk);
    #1;
    chk("R5 consumer takes writeback", ex_sel_a, SW);

    // R8: branch behind load sees two stall cycles
    @(negedge clk);
    apply('{5'd7, 5'd0, 1,0,1, 5'd7,1,1, 5'd0,0,0, 5'd0,0, 0, SR,SR,SR,SR, 8});
    #1;
    chk("R8 branch stall load in ex", stall, 1);
    @(negedge clk);
    ex_wr = 1'b0; ex_load = 1'b0; ex_rd = 5'd0;
    mem_rd = 5'd7; mem_wr = 1'b1; mem_load = 1'b1;
    #1;
    chk("R8 branch stall load in mem", stall, 1);
    @(negedge clk);
    mem_wr = 1'b0; mem_load = 1'b0; mem_rd = 5'd0;
    wb_rd = 5'd7; wb_wr = 1'b1;
    #1;
    chk("R8 branch released", stall, 0);
    chk("R7 branch takes writeback", id_sel_a, SW);

    done = 1'b1;
    summary();
  end
endmodule